// File: doc/BRIEF.md
# Turbo Decoder Stop Controller

This block decides when an iterative duo-binary turbo decoder may stop iterating. After each full iteration the decoder streams one two-bit hard decision per symbol pair, marking the final pair of the iteration. The controller keeps the previous iteration's decisions in an internal history memory and compares each incoming pair against it. One cycle after the final pair it reports whether decoding should stop, along with the number of iterations completed so far in the block.

A two-bit rule selector is captured when a new block begins. One rule runs a fixed number of iterations. One stops once two successive iterations agree over the whole block. One stops once three successive iterations all agree. Every rule is also capped by a programmed iteration limit. After a stop verdict the controller ignores further decisions until the next block start.

Top module: `tdec_stop_ctrl`

## Requirements
- R1: While reset is high and right after it falls, `res_valid`, `res_stop` and `res_iters` are all 0.
- R2: `res_valid` is high for exactly one cycle. That cycle follows the cycle in which an accepted pair had `iter_last` set. `res_iters` then gives the count of iterations finished in the current block, where the first is 1.
- R3: Rule code 2'b00 never stops early. `res_stop` is set only on the iteration whose count equals the latched limit.
- R4: Rule code 2'b11 behaves exactly like 2'b00.
- R5: Rule code 2'b01 sets `res_stop` at the end of iteration k (k of 2 or more) when every pair of iteration k equals the pair at the same position in iteration k-1.
- R6: Rule code 2'b10 sets `res_stop` at the end of iteration k only when iteration k agrees with k-1 and iteration k-1 agreed with k-2. Any disagreeing iteration restarts this run.
- R7: Agreement covers both bits (`hd_a` and `hd_b`) of every pair in the iteration. A single differing bit in any position, first or last, denies agreement for that iteration.
- R8: In every rule, `res_stop` is set when `res_iters` reaches the latched limit. `res_iters` never exceeds the limit, except that a limit of 0 acts as 1.
- R9: A `blk_start` pulse clears the iteration count, the agreement run and the history. The first iteration of a block never counts as agreeing, and its `res_iters` is 1.
- R10: `mode` and `iter_limit` are sampled only in a `blk_start` cycle. Changing them within a block has no effect on the verdicts.
- R11: After a verdict with `res_stop` set, pairs are ignored and no `res_valid` appears until the next `blk_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| blk_start | input | 1 | Begin a new code block; latches mode and limit |
| mode | input | 2 | Stop rule: 00 fixed, 01 two-agree, 10 three-agree, 11 fixed |
| iter_limit | input | ITER_W | Maximum number of full iterations |
| hd_valid | input | 1 | Hard-decision pair present this cycle |
| hd_a | input | 1 | First bit of the pair |
| hd_b | input | 1 | Second bit of the pair |
| iter_last | input | 1 | Marks the final pair of the current iteration |
| res_valid | output | 1 | Verdict pulse, one cycle after the final pair |
| res_stop | output | 1 | Decoding should stop (valid with res_valid) |
| res_iters | output | ITER_W | Iterations performed in this block |

## Verification
The hardest condition to reach is a three-agree verdict that depends on the run of agreements, and not merely on the latest comparison. The stimulus sends the sequence agree, disagree, agree, agree. The single agreement before the break must not trigger a stop, and the run must restart from zero. Single-bit differences placed at the first and at the last pair of an iteration show that neither the accumulation nor the final-pair comparison loses a mismatch. A restart part way through a block shows that history and count are discarded.

// File: rtl/tdec_stop_ctrl.sv
module tdec_stop_ctrl #(
  parameter int MAX_PAIRS = 1024,
  parameter int ITER_W = 5,
  localparam int AW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_start,
  input  logic [1:0]        mode,
  input  logic [ITER_W-1:0] iter_limit,
  input  logic              hd_valid,
  input  logic              hd_a,
  input  logic              hd_b,
  input  logic              iter_last,
  output logic              res_valid,
  output logic              res_stop,
  output logic [ITER_W-1:0] res_iters
);

  localparam logic [1:0] RULE_TWO   = 2'b01;
  localparam logic [1:0] RULE_THREE = 2'b10;

  logic [1:0]        hist [MAX_PAIRS];
  logic [AW-1:0]     addr;
  logic [ITER_W-1:0] iter_cnt, lim_q;
  logic [1:0]        mode_q, streak;
  logic              agree_acc, halted;

  wire  [1:0]        sym       = {hd_a, hd_b};
  wire               take      = hd_valid && !halted && !blk_start;
  wire               fin       = take && iter_last;
  wire               match     = (hist[addr] == sym);
  wire               first_it  = (iter_cnt == '0);
  wire               agree_now = agree_acc & match & ~first_it;
  wire  [ITER_W-1:0] iter_nxt  = iter_cnt + 1'b1;
  wire  [1:0]        streak_nx = agree_now ? ((streak == 2'd2) ? 2'd2 : streak + 2'd1) : 2'd0;
  wire               hit_lim   = (iter_nxt >= lim_q);
  wire               early     = (mode_q == RULE_TWO && agree_now) ||
                                 (mode_q == RULE_THREE && streak_nx == 2'd2);
  wire               stop_now  = hit_lim || early;

  always_ff @(posedge clk)
    if (take) hist[addr] <= sym;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr      <= '0;
      iter_cnt  <= '0;
      lim_q     <= '0;
      mode_q    <= 2'b00;
      streak    <= 2'd0;
      agree_acc <= 1'b1;
      halted    <= 1'b0;
      res_valid <= 1'b0;
      res_stop  <= 1'b0;
      res_iters <= '0;
    end else begin
      res_valid <= fin;
      res_stop  <= fin && stop_now;
      if (fin) res_iters <= iter_nxt;
      if (blk_start) begin
        addr      <= '0;
        iter_cnt  <= '0;
        lim_q     <= iter_limit;
        mode_q    <= mode;
        streak    <= 2'd0;
        agree_acc <= 1'b1;
        halted    <= 1'b0;
      end else if (take) begin
        if (iter_last) begin
          addr      <= '0;
          iter_cnt  <= iter_nxt;
          agree_acc <= 1'b1;
          streak    <= streak_nx;
          halted    <= stop_now;
        end else begin
          addr      <= addr + 1'b1;
          agree_acc <= agree_acc & match;
        end
      end
    end
  end

  assert_verdict_timing_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(hd_valid && iter_last && !halted && !blk_start));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid && !(hd_valid && iter_last && !halted && !blk_start) |=> !res_valid);

  assert_count_cap_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_iters <= lim_q || res_iters == 1));

  assert_limit_stops_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_iters >= lim_q |-> res_stop);

  assert_fixed_rule_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_stop && (mode_q[0] == mode_q[1]) |-> res_iters >= lim_q);

  assert_two_agree_depth_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_stop && mode_q == RULE_TWO && res_iters < lim_q |-> res_iters >= 2);

  assert_three_agree_depth_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_stop && mode_q == RULE_THREE && res_iters < lim_q |-> res_iters >= 3);

  assert_quiet_after_stop_R11: assert property (@(posedge clk) disable iff (rst)
    halted && !blk_start |=> !res_valid);

endmodule

// File: tb/tdec_stop_ctrl_test.sv
module tdec_stop_ctrl_test;
  localparam int NP = 8;
  localparam int IW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic blk_start = 0, hd_valid = 0, hd_a = 0, hd_b = 0, iter_last = 0;
  logic [1:0] mode = 0;
  logic [IW-1:0] iter_limit = 0;
  logic res_valid, res_stop;
  logic [IW-1:0] res_iters;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  tdec_stop_ctrl #(.MAX_PAIRS(1024), .ITER_W(IW)) uut (
    .clk(clk), .rst(rst), .blk_start(blk_start), .mode(mode), .iter_limit(iter_limit),
    .hd_valid(hd_valid), .hd_a(hd_a), .hd_b(hd_b), .iter_last(iter_last),
    .res_valid(res_valid), .res_stop(res_stop), .res_iters(res_iters));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pat_sym(input int pat, input int i);
    logic [1:0] s = 2'(i);
    if (pat == 1) s = 2'(i + 1);
    if (pat == 2 && i == NP - 1) s = s ^ 2'b10;
    if (pat == 3 && i == 0) s = s ^ 2'b01;
    return s;
  endfunction

  task automatic start_block(input logic [1:0] m, input int lim);
    @(negedge clk);
    blk_start = 1; mode = m; iter_limit = IW'(lim);
    @(negedge clk);
    blk_start = 0;
  endtask

  task automatic feed(input int pat);
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      hd_valid = 1; {hd_a, hd_b} = pat_sym(pat, i); iter_last = (i == NP - 1);
    end
  endtask

  task automatic iter(input int pat, input bit exp_stop, input int exp_it, input string req);
    feed(pat);
    @(posedge clk); #1;
    chk(res_valid == 1, req, res_valid, 1);
    chk(res_stop == exp_stop, req, res_stop, exp_stop);
    chk(res_iters == exp_it, req, res_iters, exp_it);
    @(negedge clk); hd_valid = 0; iter_last = 0;
    @(posedge clk); #1;
    chk(res_valid == 0, "R2 pulse width", res_valid, 0);
  endtask

  task automatic test_reset;
    @(posedge clk); #1;
    chk(res_valid == 0 && res_stop == 0 && res_iters == 0, "R1", {res_valid, res_stop}, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk(res_valid == 0 && res_stop == 0 && res_iters == 0, "R1", res_iters, 0);
  endtask

  task automatic test_fixed;
    start_block(2'b00, 3);
    iter(0, 0, 1, "R3"); iter(0, 0, 2, "R3"); iter(0, 1, 3, "R3");
  endtask

  task automatic test_two_agree;
    start_block(2'b01, 6);
    iter(0, 0, 1, "R5"); iter(1, 0, 2, "R5"); iter(1, 1, 3, "R5");
  endtask

  task automatic test_three_agree;
    start_block(2'b10, 8);
    iter(0, 0, 1, "R6"); iter(0, 0, 2, "R6"); iter(1, 0, 3, "R6");
    iter(1, 0, 4, "R6"); iter(1, 1, 5, "R6");
  endtask

  task automatic test_single_bit;
    start_block(2'b01, 6);
    iter(0, 0, 1, "R7"); iter(2, 0, 2, "R7 last pair a-bit");
    iter(3, 0, 3, "R7 first pair b-bit"); iter(3, 1, 4, "R7");
  endtask

  task automatic test_cap;
    start_block(2'b10, 2);
    iter(0, 0, 1, "R8"); iter(0, 1, 2, "R8 three-agree capped");
    start_block(2'b01, 2);
    iter(0, 0, 1, "R8"); iter(1, 1, 2, "R8 disagree capped");
  endtask

  task automatic test_rule11;
    start_block(2'b11, 4);
    iter(0, 0, 1, "R4"); iter(0, 0, 2, "R4"); iter(0, 0, 3, "R4"); iter(0, 1, 4, "R4");
  endtask

  task automatic test_latch_and_halt;
    start_block(2'b01, 5);
    @(negedge clk); mode = 2'b00; iter_limit = 1;
    iter(0, 0, 1, "R10"); iter(0, 1, 2, "R10");
    feed(0);
    @(negedge clk); hd_valid = 0; iter_last = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk(res_valid == 0, "R11", res_valid, 0);
    end
  endtask

  task automatic test_clear;
    start_block(2'b01, 5);
    iter(0, 0, 1, "R9 history cleared");
    start_block(2'b01, 5);
    iter(0, 0, 1, "R9 restart mid-block");
    iter(0, 1, 2, "R9");
  endtask

  initial begin
    test_reset;
    test_fixed;
    test_two_agree;
    test_three_agree;
    test_single_bit;
    test_cap;
    test_rule11;
    test_latch_and_halt;
    test_clear;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule